// File: doc/BRIEF.md
# Quad Wiper Position Bank with Step Control

This block keeps the tap position of four digitally controlled potentiometers. Each pot owns a 6-bit position register. A decoder turns the register into a one-hot select across 64 taps, so exactly one tap switch is closed. Code 00h closes the switch at the low-end terminal and code 3Fh closes the switch at the high-end terminal. The resistor ladder is outside this block. The command decoder upstream drives the strobes, the pot pointer and the register pointer. The stored data registers arrive on a flat bus.

A position changes in one of four ways:

- **Recall.** When reset is released, each pot loads its own data register 0.
- **Direct write.** The host writes a new value into the addressed pot.
- **Transfer.** A data register is copied into one addressed pot. In the global form it is copied into all four pots.
- **Stepping.** While the step command is open, each rising serial clock moves the captured pot one tap. It moves toward the high end when the serial data line is high and toward the low end when it is low. Stepping stops at both ends and never wraps.

A three-state controller handles recall and stepping:

- **ST_RECALL** is the reset state. It always passes to ST_IDLE on the first clock after reset, and that clock performs the recall.
- **ST_IDLE** passes to ST_STEP when `step_en` is high. On that transition it latches `pot_sel` as the pot to step.
- **ST_STEP** returns to ST_IDLE when `step_en` drops.

Top module: `wiper_bank`

## Requirements
- R1: For each pot, `tap_sel[p*64 +: 64]` has exactly one bit set, at the index equal to the position. Position 00h drives bit 0 (the low end) and position 3Fh drives bit 63 (the high end).
- R2: While `rst_n` is low, every position reads 0. On the first clock edge after release, pot p loads data register 0 of pot p. Data register r of pot p sits at `dr_bank[(p*4+r)*6 +: 6]`, and position p is read at `wiper_pos[p*6 +: 6]`.
- R3: Strobes and serial clock edges present on that first (recall) edge have no effect. Recall wins over every other source.
- R4: `wr_stb` loads `wr_data` into the pot addressed by `pot_sel` on the next edge. The other pots keep their values.
- R5: `xfr_stb` loads the pot addressed by `pot_sel` from its own data register `reg_sel`. The other pots keep their values.
- R6: `gxfr_stb` loads every pot from its own data register `reg_sel` on the same edge.
- R7: When several load strobes hit the same pot on one edge, `wr_stb` beats `xfr_stb`, and `xfr_stb` beats `gxfr_stb`. A pot that is not addressed by the winning single-pot strobe still takes the global load.
- R8: The step state is entered one edge after `step_en` rises, and `pot_sel` is captured on that edge. Each later edge that sees `sck` high, after an edge that saw it low, moves the captured pot by +1 if `si` is 1 or by -1 if `si` is 0. The other pots stay unchanged.
- R9: A step up from 3Fh leaves 3Fh in place, and a step down from 00h leaves 00h in place.
- R10: A load strobe on the same edge as a step edge for the same pot wins, and the step is dropped.
- R11: After `step_en` falls and the controller is back in idle, `sck` edges do not move any position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `sck` and `si` are sampled on it |
| rst_n | input | 1 | Active-low reset; recall follows its release |
| dr_bank | input | 96 | Data registers, pot-major, 6 bits each |
| pot_sel | input | 2 | Pot pointer from the command decoder |
| reg_sel | input | 2 | Data register pointer |
| wr_stb | input | 1 | Direct write strobe |
| wr_data | input | 6 | Value for the direct write |
| xfr_stb | input | 1 | Single-pot transfer strobe |
| gxfr_stb | input | 1 | All-pot transfer strobe |
| step_en | input | 1 | Step command open |
| sck | input | 1 | Serial clock level, already synchronized |
| si | input | 1 | Step direction: 1 up, 0 down |
| wiper_pos | output | 24 | Four 6-bit positions |
| tap_sel | output | 256 | Four one-hot 64-line tap selects |

## Verification
The hardest case to reach from the ports is the recall edge with competing sources present. The stimulus holds `wr_stb`, `xfr_stb` and a rising `sck` exactly across the first edge after reset release. It then checks that the register-0 values arrived and nothing else did. Saturation is reached the same way: a direct write first parks a pot at 3Fh or 00h, and the step command is opened on it afterwards. A load and a step edge are made to coincide by raising `sck` in the same cycle as the write strobe.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    localparam int POT_CNT = 4;
    localparam int REG_CNT = 4;
    localparam int POS_BITS = 6;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_STEP   = 2'd2
    } step_state_e;
endpackage

// File: rtl/wiper_step_ctl.sv
module wiper_step_ctl
    import wiper_pkg::*;
#(
    parameter int NPOT = POT_CNT,
    localparam int PSEL_W = $clog2(NPOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [PSEL_W-1:0] pot_sel,
    input  logic              sck,
    input  logic              si,
    output logic              recall,
    output logic              step_up,
    output logic              step_dn,
    output logic [PSEL_W-1:0] step_pot
);
    step_state_e state, state_nx;
    logic sck_q;
    logic sck_rise;

    assign sck_rise = sck & ~sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RECALL;
            sck_q    <= 1'b0;
            step_pot <= '0;
        end else begin
            state <= state_nx;
            sck_q <= sck;
            if (state == ST_IDLE && step_en)
                step_pot <= pot_sel;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RECALL: state_nx = ST_IDLE;
            ST_IDLE:   if (step_en) state_nx = ST_STEP;
            ST_STEP:   if (!step_en) state_nx = ST_IDLE;
            default:   state_nx = ST_RECALL;
        endcase
    end

    always_comb begin
        recall  = 1'b0;
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (state)
            ST_RECALL: recall = 1'b1;
            ST_IDLE:   ;
            ST_STEP: begin
                step_up = sck_rise & si;
                step_dn = sck_rise & ~si;
            end
            default:   recall = 1'b1;
        endcase
    end
endmodule

// File: rtl/wiper_reg.sv
module wiper_reg
    import wiper_pkg::*;
#(
    parameter int W = POS_BITS,
    localparam logic [W-1:0] TOP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         recall,
    input  logic [W-1:0] recall_val,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] pos
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos <= '0;
        else if (recall)
            pos <= recall_val;
        else if (load_en)
            pos <= load_val;
        else if (step_up && pos != TOP)
            pos <= pos + 1'b1;
        else if (step_dn && pos != '0)
            pos <= pos - 1'b1;
    end
endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import wiper_pkg::*;
#(
    parameter int W = POS_BITS,
    localparam int TAPS = 1 << W
) (
    input  logic [W-1:0]    pos,
    output logic [TAPS-1:0] sel
);
    always_comb begin
        sel = '0;
        sel[pos] = 1'b1;
    end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wiper_pkg::*;
#(
    parameter int NPOT = POT_CNT,
    parameter int NREG = REG_CNT,
    parameter int W    = POS_BITS,
    localparam int PSEL_W = $clog2(NPOT),
    localparam int RSEL_W = $clog2(NREG),
    localparam int TAPS   = 1 << W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPOT*NREG*W-1:0] dr_bank,
    input  logic [PSEL_W-1:0]      pot_sel,
    input  logic [RSEL_W-1:0]      reg_sel,
    input  logic                   wr_stb,
    input  logic [W-1:0]           wr_data,
    input  logic                   xfr_stb,
    input  logic                   gxfr_stb,
    input  logic                   step_en,
    input  logic                   sck,
    input  logic                   si,
    output logic [NPOT*W-1:0]      wiper_pos,
    output logic [NPOT*TAPS-1:0]   tap_sel
);
    logic              recall;
    logic              step_up;
    logic              step_dn;
    logic [PSEL_W-1:0] step_pot;

    wiper_step_ctl #(.NPOT(NPOT)) i_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .pot_sel  (pot_sel),
        .sck      (sck),
        .si       (si),
        .recall   (recall),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .step_pot (step_pot)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic         hit;
        logic         load_en;
        logic [W-1:0] load_val;
        logic [W-1:0] dr_pick;
        logic [W-1:0] pos;

        assign hit     = (pot_sel == PSEL_W'(p));
        assign dr_pick = dr_bank[(p*NREG + int'(reg_sel))*W +: W];

        always_comb begin
            load_en  = 1'b1;
            load_val = dr_pick;
            if (wr_stb && hit)
                load_val = wr_data;
            else if (!(xfr_stb && hit) && !gxfr_stb)
                load_en = 1'b0;
        end

        wiper_reg #(.W(W)) i_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .recall     (recall),
            .recall_val (dr_bank[(p*NREG)*W +: W]),
            .load_en    (load_en),
            .load_val   (load_val),
            .step_up    (step_up && step_pot == PSEL_W'(p)),
            .step_dn    (step_dn && step_pot == PSEL_W'(p)),
            .pos        (pos)
        );

        tap_decode #(.W(W)) i_dec (
            .pos (pos),
            .sel (tap_sel[p*TAPS +: TAPS])
        );

        assign wiper_pos[p*W +: W] = pos;
    end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
    parameter int NPOT = 4,
    parameter int NREG = 4,
    parameter int W    = 6,
    localparam int PSEL_W = $clog2(NPOT),
    localparam int TAPS   = 1 << W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPOT*NREG*W-1:0] dr_bank,
    input logic [PSEL_W-1:0]      pot_sel,
    input logic                   wr_stb,
    input logic [W-1:0]           wr_data,
    input logic                   xfr_stb,
    input logic                   gxfr_stb,
    input logic [NPOT*W-1:0]      wiper_pos,
    input logic [NPOT*TAPS-1:0]   tap_sel
);
    logic [1:0] age;
    logic       live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    assign live = (age == 2'd2);

    for (genvar k = 0; k < NPOT; k++) begin : g_chk
        // R1: exactly one tap closed per pot
        a_r1_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_sel[k*TAPS +: TAPS]) == 1);

        // R1: low-end code drives the low-end line
        a_r1_low_end: assert property (@(posedge clk) disable iff (!rst_n)
            wiper_pos[k*W +: W] == '0 |-> tap_sel[k*TAPS]);

        // R2: first edge after release recalls register 0
        a_r2_recall: assert property (@(posedge clk) disable iff (!rst_n)
            age == 2'd0 |=> wiper_pos[k*W +: W] == $past(dr_bank[k*NREG*W +: W]));

        // R4: a direct write lands in the addressed pot
        a_r4_write: assert property (@(posedge clk) disable iff (!rst_n)
            live && wr_stb && pot_sel == PSEL_W'(k) |=> wiper_pos[k*W +: W] == $past(wr_data));

        // R8: without loads a pot moves by at most one tap per edge
        a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            live && !wr_stb && !xfr_stb && !gxfr_stb |=>
                (wiper_pos[k*W +: W] == $past(wiper_pos[k*W +: W])) ||
                (wiper_pos[k*W +: W] == $past(wiper_pos[k*W +: W]) + 1'b1) ||
                (wiper_pos[k*W +: W] == $past(wiper_pos[k*W +: W]) - 1'b1));

        // R9: no wrap from the high end
        a_r9_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
            live && !wr_stb && !xfr_stb && !gxfr_stb && wiper_pos[k*W +: W] == '1 |=>
                wiper_pos[k*W +: W] != '0);

        // R9: no wrap from the low end
        a_r9_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
            live && !wr_stb && !xfr_stb && !gxfr_stb && wiper_pos[k*W +: W] == '0 |=>
                wiper_pos[k*W +: W] != '1);
    end
endmodule

bind wiper_bank wiper_bank_chk #(.NPOT(NPOT), .NREG(NREG), .W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dr_bank   (dr_bank),
    .pot_sel   (pot_sel),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .xfr_stb   (xfr_stb),
    .gxfr_stb  (gxfr_stb),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel)
);

// File: tb/test_wiper_bank.sv
module test_wiper_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] dr_bank;
    logic [1:0]  pot_sel = '0;
    logic [1:0]  reg_sel = '0;
    logic        wr_stb = 1'b0;
    logic [5:0]  wr_data = '0;
    logic        xfr_stb = 1'b0;
    logic        gxfr_stb = 1'b0;
    logic        step_en = 1'b0;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic [23:0]  wiper_pos;
    logic [255:0] tap_sel;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wiper_bank i_wiper_bank (
        .clk(clk), .rst_n(rst_n), .dr_bank(dr_bank), .pot_sel(pot_sel),
        .reg_sel(reg_sel), .wr_stb(wr_stb), .wr_data(wr_data), .xfr_stb(xfr_stb),
        .gxfr_stb(gxfr_stb), .step_en(step_en), .sck(sck), .si(si),
        .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    function automatic logic [5:0] drv(int p, int r);
        return 6'(p*16 + r*4 + 1);
    endfunction

    initial begin
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++)
                dr_bank[(p*4+r)*6 +: 6] = drv(p, r);
    end

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // fields: wr xfr gxfr pot[2] reg[2] data[6] exp3 exp2 exp1 exp0
    localparam logic [36:0] VEC [6] = '{
        {3'b100, 2'd2, 2'd0, 6'd10, 6'd49, 6'd10, 6'd17, 6'd13 - 6'd12},
        {3'b010, 2'd0, 2'd3, 6'd0,  6'd49, 6'd10, 6'd17, 6'd13},
        {3'b001, 2'd0, 2'd2, 6'd0,  6'd57, 6'd41, 6'd25, 6'd9},
        {3'b111, 2'd1, 2'd1, 6'd63, 6'd53, 6'd37, 6'd63, 6'd5},
        {3'b010, 2'd3, 2'd0, 6'd0,  6'd49, 6'd37, 6'd63, 6'd5},
        {3'b100, 2'd0, 2'd0, 6'd0,  6'd49, 6'd37, 6'd63, 6'd0}
    };

    task automatic sck_pulse(logic dir);
        si = dir;
        sck = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sck = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic open_step(logic [1:0] p);
        pot_sel = p;
        step_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R2 zero in reset", 256'(wiper_pos), 256'(0));
        check("R1 tap0 in reset", 256'(tap_sel[63:0]), 256'(64'd1));
        // R3: strobes and a rising sck on the recall edge
        wr_stb = 1'b1; wr_data = 6'd7; xfr_stb = 1'b1; gxfr_stb = 1'b1;
        reg_sel = 2'd3; sck = 1'b1; si = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; xfr_stb = 1'b0; gxfr_stb = 1'b0; sck = 1'b0;
        check("R2 R3 recall", 256'(wiper_pos), 256'({6'd49, 6'd33, 6'd17, 6'd1}));
        @(negedge clk);

        // table of load vectors (R4 R5 R6 R7)
        for (int i = 0; i < 6; i++) begin
            {wr_stb, xfr_stb, gxfr_stb} = VEC[i][36:34];
            pot_sel = VEC[i][33:32];
            reg_sel = VEC[i][31:30];
            wr_data = VEC[i][29:24];
            @(negedge clk);
            wr_stb = 1'b0; xfr_stb = 1'b0; gxfr_stb = 1'b0;
            check($sformatf("R4 R5 R6 R7 vector %0d", i), 256'(wiper_pos), 256'(VEC[i][23:0]));
        end

        // R1: ends of the range
        check("R1 low end", 256'(tap_sel[63:0]), 256'(64'd1));
        check("R1 high end", 256'(tap_sel[127:64]), 256'({1'b1, 63'd0}));
        check("R1 mid tap", 256'(tap_sel[191:128]), 256'(64'd1 << 37));

        // R9: saturation at both ends
        open_step(2'd1);
        sck_pulse(1'b1);
        check("R9 stays 3F", 256'(wiper_pos[11:6]), 256'(6'd63));
        step_en = 1'b0;
        @(negedge clk);
        open_step(2'd0);
        sck_pulse(1'b0);
        check("R9 stays 00", 256'(wiper_pos[5:0]), 256'(6'd0));
        step_en = 1'b0;
        @(negedge clk);

        // R8: stepping pot 2, with pot_sel changed after capture
        open_step(2'd2);
        pot_sel = 2'd3;
        sck_pulse(1'b1); sck_pulse(1'b1); sck_pulse(1'b1);
        check("R8 up three", 256'(wiper_pos[17:12]), 256'(6'd40));
        sck_pulse(1'b0);
        check("R8 down one", 256'(wiper_pos), 256'({6'd49, 6'd39, 6'd63, 6'd0}));

        // R10: write and step edge on the same clock
        pot_sel = 2'd2; wr_stb = 1'b1; wr_data = 6'd20;
        si = 1'b1; sck = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        sck = 1'b0;
        @(negedge clk);
        check("R10 load wins", 256'(wiper_pos[17:12]), 256'(6'd20));

        // R11: sck ignored after leaving step
        step_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sck_pulse(1'b1);
        sck_pulse(1'b0);
        check("R11 no move", 256'(wiper_pos), 256'({6'd49, 6'd20, 6'd63, 6'd0}));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule